// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Model

This block is a synthesizable, clock-sampled model of an asynchronous dynamic memory. It has a shared address bus and two active-low strobes. A row strobe falling edge selects a row and copies that row into a page buffer, which stands in for the sense amplifiers. Each column strobe falling edge then reads or overwrites one column word in the buffer. When the row strobe is released, the buffer is written back into the array. Because the whole row is restored at that point, every access also refreshes its row.

The strobes are sampled on a system clock. An edge is detected by comparing the current level of a strobe with the level sampled on the previous clock. Read data comes from a registered output that becomes valid one clock after a column edge is accepted. It is forced to zero and flagged invalid while the column strobe is high. This lets a controller or a testbench use the model in place of a real device, including page-mode bursts and refresh by a row-only cycle.

Top module: `mux_dram_model`

## Requirements
- R1: After reset every cell holds zero, `dout_valid` is 0 and `dout` is 0.
- R2: The row is taken from `addr[ROW_BITS-1:0]` on the clock that first samples `ras_n` low after it was high. Later changes on `addr` do not move the open row.
- R3: On the clock that first samples `cas_n` low while a row is open, the column is taken from `addr[COL_BITS-1:0]`. One clock later `dout_valid` is 1 and `dout` shows that column word of the open row.
- R4: If `we_n` is 0 when that column edge is sampled, the addressed word in the page buffer is replaced by `din`, and `dout` shows the new word.
- R5: One clock after `cas_n` is sampled rising, `dout_valid` is 0, and `dout` reads 0 whenever `dout_valid` is 0.
- R6: While `ras_n` stays low, repeated `cas_n` pulses with different columns all access the same open row.
- R7: On the clock that samples `ras_n` rising, the page buffer is written into the open row. Data written in one row cycle is returned by later row cycles.
- R8: A `cas_n` falling edge while no row is open has no effect: `dout_valid` stays 0 and no cell changes, even with `we_n` low.
- R9: Writes in one row cycle leave every other row unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low reset, clears array and control |
| addr | input | max(ROW_BITS,COL_BITS) | Shared row/column address bus |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at the column edge |
| din | input | DW | Write datum |
| dout | output | DW | Read datum, zero when invalid |
| dout_valid | output | 1 | High while `dout` carries a column word |

## Verification
The hardest situation to reach is a stale array row: the page buffer holds a new datum while the array still holds the old one. That difference can only be seen from the ports by closing the row and opening it again. The stimulus therefore writes inside a page, reads the result back within the same row cycle, and then reopens that row and a neighbouring row. A long run of random row cycles with random page bursts of mixed reads and writes is checked against a reference model in the bench. A column pulse with no row open, carrying an active write, is followed by a full array scan to show that it changed nothing.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;

   // Edge events of one sampled strobe
   typedef struct packed {
      logic fall;
      logic rise;
   } strobe_ev_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
   import dram_model_pkg::*;
#(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   output strobe_ev_t ev
);

   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= IDLE_LEVEL;
      else        level_q <= pin;
   end

   assign ev.fall = level_q & ~pin;
   assign ev.rise = ~level_q & pin;

endmodule

// File: rtl/dram_cells.sv
module dram_cells #(
   parameter int ROW_BITS = 3,
   parameter int LINE_W   = 8,
   localparam int ROWS    = 1 << ROW_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ROW_BITS-1:0] rd_idx,
   output logic [LINE_W-1:0]   rd_line,
   input  logic                wr_en,
   input  logic [ROW_BITS-1:0] wr_idx,
   input  logic [LINE_W-1:0]   wr_line
);

   logic [LINE_W-1:0] bank [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [LINE_W-1:0] cells_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells_q <= '0;
         else if (wr_en && (wr_idx == ROW_BITS'(r)))
            cells_q <= wr_line;
      end
      assign bank[r] = cells_q;
   end

   assign rd_line = bank[rd_idx];

   // R7: a restore lands in the addressed row
   assert_restore_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (bank[$past(wr_idx)] == $past(wr_line)));

endmodule

// File: rtl/dram_page.sv
module dram_page #(
   parameter int COL_BITS = 3,
   parameter int DW       = 1,
   localparam int COLS    = 1 << COL_BITS,
   localparam int LINE_W  = COLS * DW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [LINE_W-1:0]   load_line,
   input  logic                access,
   input  logic                strobe_off,
   input  logic                close,
   input  logic [COL_BITS-1:0] col,
   input  logic                wr,
   input  logic [DW-1:0]       din,
   output logic [LINE_W-1:0]   line,
   output logic [DW-1:0]       dout,
   output logic                dout_valid
);

   logic [LINE_W-1:0] line_q;
   logic [DW-1:0]     word_q;
   logic              valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
      end else if (load) begin
         line_q <= load_line;
      end else if (access && wr) begin
         line_q[int'(col)*DW +: DW] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         valid_q <= 1'b0;
      end else if (access) begin
         word_q  <= wr ? din : line_q[int'(col)*DW +: DW];
         valid_q <= 1'b1;
      end else if (strobe_off || close) begin
         word_q  <= '0;
         valid_q <= 1'b0;
      end
   end

   assign line       = line_q;
   assign dout       = valid_q ? word_q : '0;
   assign dout_valid = valid_q;

   // R3: an accepted column edge yields valid data one clock later
   assert_access_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      access |=> dout_valid);

   // R5: a released column strobe drops the data
   assert_release_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_off && !access) |=> (!dout_valid && dout == '0));

   // R4: a write leaves the new word in the buffer
   assert_write_buffer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (access && wr && !load) |=> (line_q[int'($past(col))*DW +: DW] == $past(din)));

endmodule

// File: rtl/mux_dram_model.sv
module mux_dram_model
   import dram_model_pkg::*;
#(
   parameter int ROW_BITS = 3,
   parameter int COL_BITS = 3,
   parameter int DW       = 1,
   localparam int AW      = max_int(ROW_BITS, COL_BITS),
   localparam int LINE_W  = (1 << COL_BITS) * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          ras_n,
   input  logic          cas_n,
   input  logic          we_n,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          dout_valid
);

   if (ROW_BITS < 1 || ROW_BITS > 10 || COL_BITS < 1 || COL_BITS > 10 || DW < 1)
   begin : g_bad_param
      $error("mux_dram_model: geometry parameters out of range");
   end

   strobe_ev_t ras_ev, cas_ev;

   strobe_edge #(.IDLE_LEVEL(1'b1)) u_ras_edge (
      .clk(clk), .rst_n(rst_n), .pin(ras_n), .ev(ras_ev));
   strobe_edge #(.IDLE_LEVEL(1'b1)) u_cas_edge (
      .clk(clk), .rst_n(rst_n), .pin(cas_n), .ev(cas_ev));

   logic                row_open_q;
   logic [ROW_BITS-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_open_q <= 1'b0;
         row_q      <= '0;
      end else if (ras_ev.fall) begin
         row_open_q <= 1'b1;
         row_q      <= addr[ROW_BITS-1:0];
      end else if (ras_ev.rise) begin
         row_open_q <= 1'b0;
      end
   end

   logic              access, restore;
   logic [LINE_W-1:0] array_line, page_line;

   assign access  = cas_ev.fall & row_open_q;
   assign restore = ras_ev.rise & row_open_q;

   dram_cells #(.ROW_BITS(ROW_BITS), .LINE_W(LINE_W)) u_cells (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(addr[ROW_BITS-1:0]), .rd_line(array_line),
      .wr_en(restore), .wr_idx(row_q), .wr_line(page_line));

   dram_page #(.COL_BITS(COL_BITS), .DW(DW)) u_page (
      .clk(clk), .rst_n(rst_n),
      .load(ras_ev.fall), .load_line(array_line),
      .access(access), .strobe_off(cas_ev.rise), .close(restore),
      .col(addr[COL_BITS-1:0]), .wr(~we_n), .din(din),
      .line(page_line), .dout(dout), .dout_valid(dout_valid));

   // R2: the open row holds while the row strobe stays low
   assert_row_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (row_open_q && !ras_ev.rise) |=> (row_open_q && $stable(row_q)));

   // R7: releasing the row strobe closes the row
   assert_row_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restore |=> !row_open_q);

   // R8: a column edge with no open row produces no data
   assert_no_row_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_ev.fall && !row_open_q) |=> !dout_valid);

endmodule

// File: tb/sim_mux_dram_model.sv
module sim_mux_dram_model;

   localparam int ROW_BITS = 3;
   localparam int COL_BITS = 3;
   localparam int DW       = 1;
   localparam int AW       = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
   localparam int ROWS     = 1 << ROW_BITS;
   localparam int COLS     = 1 << COL_BITS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_valid;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   logic [DW-1:0] ref_mem [ROWS][COLS];
   logic [DW-1:0] ref_pg  [COLS];
   int            open_r;

   always #4 clk = ~clk;

   mux_dram_model #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .din(din), .dout(dout), .dout_valid(dout_valid));

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] expect_word(input int c, input bit wr,
                                                 input logic [DW-1:0] d);
      return wr ? d : ref_pg[c];
   endfunction

   task automatic open_row(input int r);
      @(negedge clk);
      addr  = AW'(r);
      ras_n = 1'b0;
      open_r = r;
      for (int c = 0; c < COLS; c++) ref_pg[c] = ref_mem[r][c];
      @(negedge clk);
      addr = ~AW'(r);   // R2: pins move away from the row
   endtask

   task automatic close_row();
      @(negedge clk);
      ras_n = 1'b1;
      for (int c = 0; c < COLS; c++) ref_mem[open_r][c] = ref_pg[c];
      @(negedge clk);
   endtask

   task automatic col_access(input string req, input int c, input bit wr,
                             input logic [DW-1:0] d);
      logic [DW-1:0] e;
      @(negedge clk);
      addr  = AW'(c);
      we_n  = ~wr;
      din   = d;
      cas_n = 1'b0;
      e = expect_word(c, wr, d);
      if (wr) ref_pg[c] = d;
      @(negedge clk);
      chk({req, " valid"}, int'(dout_valid), 1);
      chk({req, " data"}, int'(dout), int'(e));
      cas_n = 1'b1;
      we_n  = 1'b1;
      addr  = '1;
      @(negedge clk);
      chk("R5 valid after release", int'(dout_valid), 0);
      chk("R5 zero after release", int'(dout), 0);
   endtask

   task automatic scan_all(input string req);
      for (int r = 0; r < ROWS; r++) begin
         open_row(r);
         for (int c = 0; c < COLS; c++) col_access(req, c, 1'b0, '0);
         close_row();
      end
   endtask

   initial begin
      repeat (2000000 / 16) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) ref_mem[r][c] = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset valid", int'(dout_valid), 0);
      chk("R1 reset data", int'(dout), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 and R6: all-zero array, full page burst on every row
      scan_all("R1 R6 initial");

      // R4 R6: write then read back inside one page
      open_row(2);
      col_access("R4 write", 3, 1'b1, 1'b1);
      col_access("R6 page read", 3, 1'b0, '0);
      col_access("R6 other column", 4, 1'b0, '0);
      close_row();
      // R7: restored data visible in a new row cycle
      open_row(2);
      col_access("R7 reopen", 3, 1'b0, '0);
      close_row();
      // R9: neighbouring row unchanged
      open_row(3);
      col_access("R9 other row", 3, 1'b0, '0);
      close_row();

      // R8: column pulse with an active write and no open row
      @(negedge clk);
      addr  = AW'(5);
      we_n  = 1'b0;
      din   = 1'b1;
      cas_n = 1'b0;
      @(negedge clk);
      chk("R8 no valid", int'(dout_valid), 0);
      chk("R8 no data", int'(dout), 0);
      cas_n = 1'b1;
      we_n  = 1'b1;
      @(negedge clk);
      scan_all("R8 no cell changed");

      // Random row cycles with page bursts (R3 R4 R6 R7 R9)
      for (int i = 0; i < 60; i++) begin
         int r, n;
         r = int'($urandom_range(ROWS - 1));
         n = 1 + int'($urandom_range(4));
         open_row(r);
         for (int k = 0; k < n; k++) begin
            int  c;
            bit  w;
            c = int'($urandom_range(COLS - 1));
            w = bit'($urandom_range(1));
            col_access(w ? "R4 random write" : "R3 random read", c, w,
                       DW'($urandom));
         end
         close_row();
      end

      scan_all("R7 R9 final");

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule